// File: doc/BRIEF.md
# Speculative Register Status and Checkpoint Merge

This block tracks, for every architectural register, four status bits that steer a two-checkpoint speculative episode. The bits are: pending (the value is still missing), snapshot-pending (a copy of pending taken when the trailing thread starts), written (the trailing thread has produced the value) and overwritten (the leading thread wrote the register again after the snapshot). It also runs the mode sequence from normal operation through lead-only speculation to a phase where the trailing thread is active, and back again.

The leading thread reports register results, each either resolved or deferred. The trailing thread reports the registers it completes. The queue logic reports when the deferred work of the current checkpoint, or of all checkpoints, is drained, and the speculation logic reports a failure. In return the block gives a commit mask naming the speculative register values that may enter architectural state, a mode code, and a one-cycle restore pulse. Register data and instruction execution live outside the block. All pins are plain control and status signals with no handshake. Every event is sampled at the rising clock edge, and every output is registered apart from the commit mask, which is decoded from registered state.

Top module: `spec_status_core`

## Requirements
- R1: After reset the mode is normal (code 0), all four vectors are zero, the commit mask is zero and the restore pulse is low.
- R2: A start event in normal mode moves the mode to lead-only speculation (code 1) and clears all vectors. A start event in any other mode is ignored.
- R3: In modes 1 and 2, a leading-thread write sets the pending bit of the indexed register to the supplied value (1 = deferred, 0 = resolved) on the next edge. Such writes are ignored in normal mode.
- R4: A wake event in mode 1 moves the mode to trailing-active (code 2), clears the written vector, and loads the snapshot vector with the pending vector as updated by the same cycle's leading write. A wake event in other modes is ignored.
- R5: In mode 2, a trailing-thread write sets the written bit of the indexed register. Such writes are ignored in other modes.
- R6: In mode 2, every register whose pending bit (after the same cycle's leading write) differs from its snapshot bit gets its overwritten bit set. That bit stays set until the episode's merge, join or failure.
- R7: The commit mask equals written AND NOT overwritten while in mode 2, and is zero in the other modes.
- R8: In mode 2, current-queue-empty without all-empty performs a merge. Pending becomes snapshot AND written, the snapshot, written and overwritten vectors clear, the writes of that cycle are dropped, and the mode returns to 1.
- R9: In mode 2, all-empty performs a join. It updates the vectors exactly as a merge does and returns the mode to normal. Both queue-empty indications are ignored outside mode 2.
- R10: A failure in mode 1 or 2 clears all four vectors, sets the mode to normal and raises the restore output for exactly one cycle. A failure overrides start, wake, merge and join in the same cycle, and is ignored in normal mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a speculative episode |
| wake_i | input | 1 | Trailing thread wakes; speculative checkpoint goes active |
| ahd_wr_en_i | input | 1 | Leading-thread register result valid |
| ahd_wr_idx_i | input | IW | Register index of leading-thread result |
| ahd_wr_nt_i | input | 1 | 1 = result deferred (pending), 0 = resolved |
| bhd_wr_en_i | input | 1 | Trailing-thread register completion valid |
| bhd_wr_idx_i | input | IW | Register index of trailing-thread completion |
| q_cur_empty_i | input | 1 | Deferred work of current checkpoint drained |
| q_all_empty_i | input | 1 | Deferred work of all checkpoints drained |
| fail_i | input | 1 | Speculation failed |
| mode_o | output | 2 | 0 normal, 1 lead-only, 2 trailing-active |
| nt_o | output | NREGS | Pending vector |
| snt_o | output | NREGS | Snapshot-pending vector |
| wr_o | output | NREGS | Written vector |
| waw_o | output | NREGS | Overwritten vector |
| commit_o | output | NREGS | Registers whose speculative value may commit |
| restore_o | output | 1 | One-cycle pulse: restore architectural checkpoint |

## Verification
The assertions assume that the queue-empty flags and the failure input describe the mode the block is in. They also assume that a wake event with no leading write in the same cycle leaves the pending vector unchanged from the sampled value. The properties depend on nothing else about the inputs. The stimulus deliberately goes past these assumptions: every event pin is driven at random in every mode, so ignored events, failures colliding with merges and joins, and writes in the wake cycle all occur. Register indices sweep the whole register space of a four-register instance.

// File: rtl/spec_status_pkg.sv
package spec_status_pkg;

  typedef enum logic [1:0] {
    MODE_NORMAL = 2'd0,
    MODE_AHEAD  = 2'd1,
    MODE_BEHIND = 2'd2
  } spec_mode_e;

  // Events after mode qualification and priority resolution
  typedef struct packed {
    logic start;
    logic wake;
    logic fold_cur;
    logic fold_all;
    logic fail;
  } spec_evt_t;

endpackage

// File: rtl/spec_mode_fsm.sv
module spec_mode_fsm
  import spec_status_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic       wake_i,
  input  logic       q_cur_empty_i,
  input  logic       q_all_empty_i,
  input  logic       fail_i,
  output spec_mode_e mode_o,
  output spec_evt_t  evt_o,
  output logic       restore_o
);

  spec_mode_e mode_q, mode_d;
  logic       restore_q;

  // Failure outranks everything; queue-empty and wake only count in their modes
  always_comb begin
    evt_o.fail     = fail_i && (mode_q != MODE_NORMAL);
    evt_o.start    = start_i && (mode_q == MODE_NORMAL);
    evt_o.wake     = !evt_o.fail && wake_i && (mode_q == MODE_AHEAD);
    evt_o.fold_all = !evt_o.fail && q_all_empty_i && (mode_q == MODE_BEHIND);
    evt_o.fold_cur = !evt_o.fail && q_cur_empty_i && !q_all_empty_i
                     && (mode_q == MODE_BEHIND);
  end

  always_comb begin
    mode_d = mode_q;
    if (evt_o.fail)          mode_d = MODE_NORMAL;
    else if (evt_o.start)    mode_d = MODE_AHEAD;
    else if (evt_o.wake)     mode_d = MODE_BEHIND;
    else if (evt_o.fold_all) mode_d = MODE_NORMAL;
    else if (evt_o.fold_cur) mode_d = MODE_AHEAD;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q    <= MODE_NORMAL;
      restore_q <= 1'b0;
    end else begin
      mode_q    <= mode_d;
      restore_q <= evt_o.fail;
    end
  end

  assign mode_o    = mode_q;
  assign restore_o = restore_q;

endmodule

// File: rtl/spec_vec_bank.sv
module spec_vec_bank
  import spec_status_pkg::*;
#(
  parameter int NREGS = 32,
  localparam int IW = (NREGS > 1) ? $clog2(NREGS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  spec_mode_e       mode_i,
  input  spec_evt_t        evt_i,
  input  logic             ahd_wr_en_i,
  input  logic [IW-1:0]    ahd_wr_idx_i,
  input  logic             ahd_wr_nt_i,
  input  logic             bhd_wr_en_i,
  input  logic [IW-1:0]    bhd_wr_idx_i,
  output logic [NREGS-1:0] nt_o,
  output logic [NREGS-1:0] snt_o,
  output logic [NREGS-1:0] wr_o,
  output logic [NREGS-1:0] waw_o
);

  logic [NREGS-1:0] nt_q, snt_q, wr_q, waw_q;
  logic             ahd_ok, bhd_ok, clear_all, fold;

  assign ahd_ok    = ahd_wr_en_i && (mode_i != MODE_NORMAL);
  assign bhd_ok    = bhd_wr_en_i && (mode_i == MODE_BEHIND);
  assign clear_all = evt_i.fail || evt_i.start;
  assign fold      = evt_i.fold_cur || evt_i.fold_all;

  for (genvar i = 0; i < NREGS; i++) begin : g_reg
    logic nt_upd, bhd_hit;

    assign nt_upd  = (ahd_ok && (ahd_wr_idx_i == IW'(i))) ? ahd_wr_nt_i : nt_q[i];
    assign bhd_hit = bhd_ok && (bhd_wr_idx_i == IW'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        nt_q[i]  <= 1'b0;
        snt_q[i] <= 1'b0;
        wr_q[i]  <= 1'b0;
        waw_q[i] <= 1'b0;
      end else if (clear_all) begin
        nt_q[i]  <= 1'b0;
        snt_q[i] <= 1'b0;
        wr_q[i]  <= 1'b0;
        waw_q[i] <= 1'b0;
      end else if (fold) begin
        nt_q[i]  <= snt_q[i] & wr_q[i];
        snt_q[i] <= 1'b0;
        wr_q[i]  <= 1'b0;
        waw_q[i] <= 1'b0;
      end else if (evt_i.wake) begin
        nt_q[i]  <= nt_upd;
        snt_q[i] <= nt_upd;
        wr_q[i]  <= 1'b0;
        waw_q[i] <= 1'b0;
      end else begin
        nt_q[i] <= nt_upd;
        if (mode_i == MODE_BEHIND) begin
          wr_q[i]  <= wr_q[i] | bhd_hit;
          waw_q[i] <= waw_q[i] | (nt_upd ^ snt_q[i]);
        end
      end
    end
  end

  assign nt_o  = nt_q;
  assign snt_o = snt_q;
  assign wr_o  = wr_q;
  assign waw_o = waw_q;

endmodule

// File: rtl/spec_status_core.sv
module spec_status_core
  import spec_status_pkg::*;
#(
  parameter int NREGS = 32,
  localparam int IW = (NREGS > 1) ? $clog2(NREGS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             wake_i,
  input  logic             ahd_wr_en_i,
  input  logic [IW-1:0]    ahd_wr_idx_i,
  input  logic             ahd_wr_nt_i,
  input  logic             bhd_wr_en_i,
  input  logic [IW-1:0]    bhd_wr_idx_i,
  input  logic             q_cur_empty_i,
  input  logic             q_all_empty_i,
  input  logic             fail_i,
  output logic [1:0]       mode_o,
  output logic [NREGS-1:0] nt_o,
  output logic [NREGS-1:0] snt_o,
  output logic [NREGS-1:0] wr_o,
  output logic [NREGS-1:0] waw_o,
  output logic [NREGS-1:0] commit_o,
  output logic             restore_o
);

  spec_mode_e mode;
  spec_evt_t  evt;

  spec_mode_fsm u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .start_i       (start_i),
    .wake_i        (wake_i),
    .q_cur_empty_i (q_cur_empty_i),
    .q_all_empty_i (q_all_empty_i),
    .fail_i        (fail_i),
    .mode_o        (mode),
    .evt_o         (evt),
    .restore_o     (restore_o)
  );

  spec_vec_bank #(.NREGS(NREGS)) u_bank (
    .clk          (clk),
    .rst_n        (rst_n),
    .mode_i       (mode),
    .evt_i        (evt),
    .ahd_wr_en_i  (ahd_wr_en_i),
    .ahd_wr_idx_i (ahd_wr_idx_i),
    .ahd_wr_nt_i  (ahd_wr_nt_i),
    .bhd_wr_en_i  (bhd_wr_en_i),
    .bhd_wr_idx_i (bhd_wr_idx_i),
    .nt_o         (nt_o),
    .snt_o        (snt_o),
    .wr_o         (wr_o),
    .waw_o        (waw_o)
  );

  assign mode_o   = mode;
  assign commit_o = (mode == MODE_BEHIND) ? (wr_o & ~waw_o) : '0;

  AST_MERGE_FOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 2'd2 && !fail_i && q_cur_empty_i && !q_all_empty_i)
    |=> (mode_o == 2'd1 && nt_o == $past(snt_o & wr_o) && snt_o == '0
         && wr_o == '0 && waw_o == '0)); // R8

  AST_JOIN_NORMAL: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 2'd2 && !fail_i && q_all_empty_i)
    |=> (mode_o == 2'd0 && nt_o == $past(snt_o & wr_o) && waw_o == '0)); // R9

  AST_FAIL_RESTORE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o != 2'd0 && fail_i)
    |=> (mode_o == 2'd0 && restore_o && nt_o == '0 && snt_o == '0
         && wr_o == '0 && waw_o == '0)); // R10

  AST_WAKE_SNAPSHOT: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 2'd1 && wake_i && !fail_i && !ahd_wr_en_i)
    |=> (mode_o == 2'd2 && snt_o == $past(nt_o) && wr_o == '0)); // R4

  AST_WAW_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 2'd2 && !fail_i && !q_cur_empty_i && !q_all_empty_i)
    |=> ((waw_o & $past(waw_o)) == $past(waw_o))); // R6

endmodule

// File: tb/spec_status_core_test.sv
`timescale 1ns/1ps
module spec_status_core_test;

  localparam int N  = 4;
  localparam int IW = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_i = 0, wake_i = 0, ahd_wr_en_i = 0, ahd_wr_nt_i = 0;
  logic [IW-1:0] ahd_wr_idx_i = '0, bhd_wr_idx_i = '0;
  logic          bhd_wr_en_i = 0, q_cur_empty_i = 0, q_all_empty_i = 0, fail_i = 0;
  logic [1:0]    mode_o;
  logic [N-1:0]  nt_o, snt_o, wr_o, waw_o, commit_o;
  logic          restore_o;

  int vectors = 0;
  int miscompares = 0;

  always #5 clk = ~clk;

  spec_status_core #(.NREGS(N)) uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .wake_i(wake_i),
    .ahd_wr_en_i(ahd_wr_en_i), .ahd_wr_idx_i(ahd_wr_idx_i), .ahd_wr_nt_i(ahd_wr_nt_i),
    .bhd_wr_en_i(bhd_wr_en_i), .bhd_wr_idx_i(bhd_wr_idx_i),
    .q_cur_empty_i(q_cur_empty_i), .q_all_empty_i(q_all_empty_i), .fail_i(fail_i),
    .mode_o(mode_o), .nt_o(nt_o), .snt_o(snt_o), .wr_o(wr_o), .waw_o(waw_o),
    .commit_o(commit_o), .restore_o(restore_o)
  );

  // expected state
  logic [1:0]   e_mode;
  logic [N-1:0] e_nt, e_snt, e_wr, e_waw;
  logic         e_rst;

  task automatic check(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    logic [N-1:0] e_commit;
    e_commit = (e_mode == 2'd2) ? (e_wr & ~e_waw) : '0;
    check("R2 mode",        mode_o,    e_mode);
    check("R3 pending",     nt_o,      e_nt);
    check("R4 snapshot",    snt_o,     e_snt);
    check("R5 written",     wr_o,      e_wr);
    check("R6 overwritten", waw_o,     e_waw);
    check("R7 commit",      commit_o,  e_commit);
    check("R10 restore",    restore_o, e_rst);
  endtask

  initial begin : watchdog
    #1000000;
    miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin : stim
    logic [N-1:0] nt_u, nx_nt, nx_snt, nx_wr, nx_waw;
    logic [1:0]   nx_mode;
    logic         f, fa, fc, wk, st;
    e_mode = 0; e_nt = 0; e_snt = 0; e_wr = 0; e_waw = 0; e_rst = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    compare_all();
    rst_n = 1'b1;
    for (int cyc = 0; cyc < 4000; cyc++) begin
      @(negedge clk);
      compare_all();
      start_i       = ($urandom_range(0, 3) == 0);
      wake_i        = ($urandom_range(0, 5) == 0);
      q_cur_empty_i = ($urandom_range(0, 9) == 0);
      q_all_empty_i = ($urandom_range(0, 15) == 0);
      fail_i        = ($urandom_range(0, 39) == 0);
      ahd_wr_en_i   = $urandom_range(0, 1);
      ahd_wr_idx_i  = IW'($urandom_range(0, N - 1));
      ahd_wr_nt_i   = $urandom_range(0, 1);
      bhd_wr_en_i   = $urandom_range(0, 1);
      bhd_wr_idx_i  = IW'($urandom_range(0, N - 1));
      // next expected state, from the requirements
      f  = fail_i && e_mode != 0;                                  // R10
      st = start_i && e_mode == 0;                                 // R2
      wk = !f && wake_i && e_mode == 1;                            // R4
      fa = !f && q_all_empty_i && e_mode == 2;                     // R9
      fc = !f && q_cur_empty_i && !q_all_empty_i && e_mode == 2;   // R8
      nt_u = e_nt;
      if (ahd_wr_en_i && e_mode != 0) nt_u[ahd_wr_idx_i] = ahd_wr_nt_i; // R3
      nx_mode = e_mode; nx_nt = nt_u; nx_snt = e_snt; nx_wr = e_wr; nx_waw = e_waw;
      if (f || st) begin
        nx_mode = f ? 2'd0 : 2'd1;
        nx_nt = 0; nx_snt = 0; nx_wr = 0; nx_waw = 0;
      end else if (fa || fc) begin
        nx_mode = fa ? 2'd0 : 2'd1;
        nx_nt = e_snt & e_wr; nx_snt = 0; nx_wr = 0; nx_waw = 0;
      end else if (wk) begin
        nx_mode = 2'd2; nx_snt = nt_u; nx_wr = 0; nx_waw = 0;
      end else if (e_mode == 2) begin
        if (bhd_wr_en_i) nx_wr[bhd_wr_idx_i] = 1'b1;               // R5
        for (int b = 0; b < N; b++)
          if (nt_u[b] != e_snt[b]) nx_waw[b] = 1'b1;               // R6
      end
      @(posedge clk);
      #1;
      e_mode = nx_mode; e_nt = nx_nt; e_snt = nx_snt; e_wr = nx_wr; e_waw = nx_waw;
      e_rst = f;
    end
    @(negedge clk);
    compare_all();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule